// File: doc/BRIEF.md
# Microstepping Stepper Phase Sequencer

This block turns a step pulse and a direction level into winding drive codes for a two-phase unipolar stepper motor. An electrical cycle is split into 64 positions, and a position counter moves on each qualifying edge of the step input. For each winding the block derives a polarity select and a current-level code from a quarter-wave sine table. A separate current regulator turns those codes into motor current. A mode word picks one of five resolutions, from full steps down to sixteenth steps. The same word also decides whether only rising edges of the step input count, or both edges.

Monitor outputs report which quadrant the position is in and whether it sits at the origin. The origin is the 45-degree point, where both windings carry about 71 % of full scale. A rising edge on the home input snaps the position back to the origin without a reset. Dropping the enable input switches both windings off and freezes the position. The step input is expected to be already filtered and synchronous to the system clock.

Top module: `ustep_sequencer`

## Requirements
- R1: While rstN is low the position is forced to the origin in any mode. At the origin the outputs read levelA = levelB = 71, phaseNeg = 00, quadMon = 10 and awayFromHome = 0. The first clock edge after release only samples the inputs and never moves the position.
- R2: Each counted edge moves the position by a fixed amount out of 64 per electrical cycle. With risingOnly = 1, resSel values 0, 1, 2 and 3 give 16, 8, 4 and 2. With risingOnly = 0, the same values give 8, 4, 2 and 1.
- R3: With risingOnly = 1 only rising edges of stepLevel are counted. With risingOnly = 0 both rising and falling edges are counted.
- R4: With dirCw = 1 a counted edge increases the position. With dirCw = 0 it decreases the position.
- R5: The position wraps modulo 64 in both directions.
- R6: A counted edge that finds the position off the grid of the current mode moves to the nearest grid point in the direction of travel. The grid is the set of multiples of the step size. A new mode therefore takes effect on the next counted edge.
- R7: A rising edge of homeReq puts the position at the origin. It wins over a step counted in the same cycle. Holding homeReq high, or lowering it, has no effect.
- R8: While enable is low, levelA = levelB = 0 and phaseOff = 11. Neither step edges nor home edges change the position. Edges seen while disabled are lost, and re-enabling causes no step.
- R9: Define θ = (position + 8) × 5.625°. levelB = round(100·|sin θ|) and levelA = round(100·|cos θ|). phaseNeg[1] is 1 for θ in [180°, 360°). phaseNeg[0] is 1 for θ in [90°, 270°).
- R10: quadMon gives the quadrant floor(position / 16): values 0, 1, 2 and 3 read 10, 01, 00 and 11. awayFromHome is 1 exactly when the position is not 0.
- R11: phaseOff[0] (winding A) and phaseOff[1] (winding B) are 1 when that winding's level is 0 or the block is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stepLevel | input | 1 | Filtered step pulse level; its edges move the position |
| dirCw | input | 1 | Direction: 1 counts up, 0 counts down |
| risingOnly | input | 1 | 1: only rising step edges count; 0: both edges count |
| resSel | input | 2 | Resolution select within the edge mode |
| homeReq | input | 1 | A rising edge returns the position to the origin |
| enable | input | 1 | 0 turns the windings off and freezes the position |
| phaseNeg | output | 2 | Winding polarity, bit 0 = A, bit 1 = B |
| levelA | output | 7 | Winding A current level in percent |
| levelB | output | 7 | Winding B current level in percent |
| phaseOff | output | 2 | Winding off flag, bit 0 = A, bit 1 = B |
| quadMon | output | 2 | Quadrant monitor code |
| awayFromHome | output | 1 | 1 when the position is not the origin |

## Verification
All eight mode words are swept with a long run of step toggles upward, long enough to wrap, and then a shorter run downward. This separates the step sizes, the rising-only and both-edge counting, the direction and the wrap. Every output is compared against sine, cosine and quadrant values computed from the position. A fine-to-coarse and a coarse-to-fine mode change from an off-grid position show whether realignment rounds in the direction of travel. Home edges are tried alone, held high, released, and together with a step. Disabled periods that contain step and home edges show that the position is frozen and that no phantom step appears on re-enable.

// File: rtl/ustep_pkg.sv
package ustep_pkg;
  localparam int unsigned POS_W   = 6;               // 64 positions per electrical cycle
  localparam int unsigned QTR_W   = POS_W - 2;       // bits within one quadrant
  localparam int unsigned QTR_N   = 1 << QTR_W;      // positions per quadrant
  localparam int unsigned MAG_W   = QTR_W + 1;       // magnitude index 0..QTR_N
  localparam int unsigned SHIFT_W = $clog2(QTR_W + 1);
  localparam int unsigned LVL_W   = 7;               // level in percent, 0..100
  localparam int unsigned HOME_OFS = QTR_N / 2;      // origin sits at 45 degrees

  typedef logic [POS_W-1:0] pos_t;

  // strobes from control to datapath
  typedef struct packed {
    logic               moveUp;
    logic               moveDown;
    logic               goHome;
    logic [SHIFT_W-1:0] stepShift;
  } seqCmd_t;

  // quarter-wave sine in percent, index k -> round(100*sin(k*90/16 deg))
  function automatic logic [LVL_W-1:0] sineLevel(input logic [MAG_W-1:0] mag);
    case (mag)
      5'd0:    sineLevel = 7'd0;
      5'd1:    sineLevel = 7'd10;
      5'd2:    sineLevel = 7'd20;
      5'd3:    sineLevel = 7'd29;
      5'd4:    sineLevel = 7'd38;
      5'd5:    sineLevel = 7'd47;
      5'd6:    sineLevel = 7'd56;
      5'd7:    sineLevel = 7'd63;
      5'd8:    sineLevel = 7'd71;
      5'd9:    sineLevel = 7'd77;
      5'd10:   sineLevel = 7'd83;
      5'd11:   sineLevel = 7'd88;
      5'd12:   sineLevel = 7'd92;
      5'd13:   sineLevel = 7'd96;
      5'd14:   sineLevel = 7'd98;
      5'd15:   sineLevel = 7'd100;
      default: sineLevel = 7'd100;
    endcase
  endfunction
endpackage

// File: rtl/ustep_ctrl.sv
module ustep_ctrl
  import ustep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       stepLevel,
  input  logic       dirCw,
  input  logic       risingOnly,
  input  logic [1:0] resSel,
  input  logic       homeReq,
  output seqCmd_t    cmd
);
  logic stepPrev, homePrev, primed;
  logic stepRise, stepFall, stepEdge, homeRise;
  logic [SHIFT_W-1:0] coarseShift;

  // edge history; primed masks the first edge after reset (R1)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stepPrev <= 1'b0;
      homePrev <= 1'b0;
      primed   <= 1'b0;
    end else begin
      stepPrev <= stepLevel;
      homePrev <= homeReq;
      primed   <= 1'b1;
    end
  end

  always_comb begin
    stepRise = primed & stepLevel & ~stepPrev;
    stepFall = primed & ~stepLevel & stepPrev;
    stepEdge = stepRise | (stepFall & ~risingOnly);               // R3
    homeRise = primed & homeReq & ~homePrev;                      // R7
    coarseShift = SHIFT_W'(QTR_W) - SHIFT_W'(resSel);             // R2
    cmd.stepShift = risingOnly ? coarseShift : coarseShift - SHIFT_W'(1);
    cmd.goHome    = enable & homeRise;                            // R8 gating
    cmd.moveUp    = enable & stepEdge & dirCw & ~homeRise;        // R4
    cmd.moveDown  = enable & stepEdge & ~dirCw & ~homeRise;
  end
endmodule

// File: rtl/ustep_datapath.sv
module ustep_datapath
  import ustep_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  seqCmd_t          cmd,
  output logic [1:0]       phaseNeg,
  output logic [LVL_W-1:0] levelA,
  output logic [LVL_W-1:0] levelB,
  output logic [1:0]       phaseOff,
  output logic [1:0]       quadMon,
  output logic             awayFromHome
);
  pos_t posQ, stepMask, upNext, downNext, elecPos;
  logic [1:0][LVL_W-1:0] lvl;

  // next position snaps onto the grid of the current step size (R6)
  always_comb begin
    stepMask = (pos_t'(1) << cmd.stepShift) - pos_t'(1);
    upNext   = (posQ | stepMask) + pos_t'(1);
    downNext = (posQ - pos_t'(1)) & ~stepMask;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            posQ <= '0;
    else if (cmd.goHome)  posQ <= '0;
    else if (cmd.moveUp)  posQ <= upNext;
    else if (cmd.moveDown) posQ <= downNext;
  end

  assign elecPos = posQ + pos_t'(HOME_OFS);

  // winding 0 (A) follows cosine, winding 1 (B) follows sine (R9, R11)
  for (genvar g = 0; g < 2; g++) begin : g_phase
    localparam pos_t PH_OFS = (g == 0) ? pos_t'(QTR_N) : pos_t'(0);
    pos_t             ang;
    logic [MAG_W-1:0] mag;
    assign ang = elecPos + PH_OFS;
    assign mag = ang[QTR_W] ? MAG_W'(QTR_N) - MAG_W'(ang[QTR_W-1:0])
                            : MAG_W'(ang[QTR_W-1:0]);
    assign phaseNeg[g] = ang[POS_W-1];
    assign lvl[g]      = enable ? sineLevel(mag) : '0;
    assign phaseOff[g] = ~enable | (mag == '0);
  end

  assign levelA = lvl[0];
  assign levelB = lvl[1];

  // quadrant monitor (R10)
  always_comb begin
    case (posQ[POS_W-1 -: 2])
      2'd0:    quadMon = 2'b10;
      2'd1:    quadMon = 2'b01;
      2'd2:    quadMon = 2'b00;
      default: quadMon = 2'b11;
    endcase
    awayFromHome = |posQ;
  end
endmodule

// File: rtl/ustep_sequencer.sv
module ustep_sequencer
  import ustep_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             stepLevel,
  input  logic             dirCw,
  input  logic             risingOnly,
  input  logic [1:0]       resSel,
  input  logic             homeReq,
  input  logic             enable,
  output logic [1:0]       phaseNeg,
  output logic [LVL_W-1:0] levelA,
  output logic [LVL_W-1:0] levelB,
  output logic [1:0]       phaseOff,
  output logic [1:0]       quadMon,
  output logic             awayFromHome
);
  seqCmd_t seqCmd;

  ustep_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .stepLevel  (stepLevel),
    .dirCw      (dirCw),
    .risingOnly (risingOnly),
    .resSel     (resSel),
    .homeReq    (homeReq),
    .cmd        (seqCmd)
  );

  ustep_datapath u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .cmd          (seqCmd),
    .phaseNeg     (phaseNeg),
    .levelA       (levelA),
    .levelB       (levelB),
    .phaseOff     (phaseOff),
    .quadMon      (quadMon),
    .awayFromHome (awayFromHome)
  );
endmodule

// File: rtl/ustep_checker.sv
module ustep_checker
  import ustep_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             stepLevel,
  input logic             risingOnly,
  input logic             homeReq,
  input logic             enable,
  input logic [1:0]       phaseNeg,
  input logic [LVL_W-1:0] levelA,
  input logic [LVL_W-1:0] levelB,
  input logic [1:0]       phaseOff,
  input logic [1:0]       quadMon,
  input logic             awayFromHome
);
  p_disabled_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (phaseOff == 2'b11 && levelA == '0 && levelB == '0));

  p_disabled_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(quadMon) && $stable(awayFromHome) && $stable(phaseNeg)));

  p_origin_outputs_r1: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !awayFromHome) |->
      (levelA == 7'd71 && levelB == 7'd71 && phaseNeg == 2'b00 && quadMon == 2'b10));

  p_unit_circle_r9: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> ((int'(levelA) * int'(levelA) + int'(levelB) * int'(levelB)) >= 9800 &&
                (int'(levelA) * int'(levelA) + int'(levelB) * int'(levelB)) <= 10200));

  p_off_flag_r11: assert property (@(posedge clk) disable iff (!rstN)
    enable |-> (phaseOff[0] == (levelA == '0) && phaseOff[1] == (levelB == '0)));

  p_home_edge_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && enable && $rose(homeReq)) |=> !awayFromHome);

  p_quiet_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($stable(stepLevel) && $stable(homeReq) && $stable(enable)) |=>
      ($stable(quadMon) && $stable(phaseNeg) && $stable(levelA) && $stable(levelB)));

  p_fall_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
    (risingOnly && $fell(stepLevel) && $stable(homeReq) && $stable(enable)) |=>
      ($stable(quadMon) && $stable(phaseNeg) && $stable(levelA) && $stable(levelB)));
endmodule

bind ustep_sequencer ustep_checker u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .stepLevel    (stepLevel),
  .risingOnly   (risingOnly),
  .homeReq      (homeReq),
  .enable       (enable),
  .phaseNeg     (phaseNeg),
  .levelA       (levelA),
  .levelB       (levelB),
  .phaseOff     (phaseOff),
  .quadMon      (quadMon),
  .awayFromHome (awayFromHome)
);

// File: tb/tb_ustep_sequencer.sv
`timescale 1ns/1ps
module tb_ustep_sequencer;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stepLevel = 1'b0;
  logic       dirCw = 1'b1;
  logic       risingOnly = 1'b1;
  logic [1:0] resSel = 2'd0;
  logic       homeReq = 1'b0;
  logic       enable = 1'b1;
  logic [1:0] phaseNeg;
  logic [6:0] levelA, levelB;
  logic [1:0] phaseOff;
  logic [1:0] quadMon;
  logic       awayFromHome;

  int  checks = 0;
  int  errors = 0;
  int  expPos = 0;
  bit  finished = 0;

  always #10 clk = ~clk;   // 50 MHz

  ustep_sequencer dut (
    .clk(clk), .rstN(rstN), .stepLevel(stepLevel), .dirCw(dirCw),
    .risingOnly(risingOnly), .resSel(resSel), .homeReq(homeReq), .enable(enable),
    .phaseNeg(phaseNeg), .levelA(levelA), .levelB(levelB), .phaseOff(phaseOff),
    .quadMon(quadMon), .awayFromHome(awayFromHome)
  );

  // R2: positions per counted edge
  function automatic int stepOf(bit ro, logic [1:0] rs);
    return 1 << ((ro ? 4 : 3) - int'(rs));
  endfunction

  // R4, R5, R6: move to next grid point in the direction of travel
  function automatic int advance(int p, bit up, int s);
    if (up) return (((p / s) + 1) * s) % 64;
    if (p % s != 0) return p - (p % s);
    return (p - s + 64) % 64;
  endfunction

  function automatic int pct(real x);
    real ax;
    ax = (x < 0.0) ? -x : x;
    return $rtoi(100.0 * ax + 0.5);
  endfunction

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic checkAll(string tag);
    int a, eA, eB;
    real th;
    logic [20:0] act, exp;
    logic [1:0] eQ, eNeg, eOff;
    a  = (expPos + 8) % 64;
    th = a * 2.0 * 3.14159265358979 / 64.0;
    eA = enable ? pct($cos(th)) : 0;
    eB = enable ? pct($sin(th)) : 0;
    eNeg = {a >= 32, (a >= 16 && a < 48)};
    eOff = {!enable || eB == 0, !enable || eA == 0};
    case (expPos / 16)
      0: eQ = 2'b10;
      1: eQ = 2'b01;
      2: eQ = 2'b00;
      default: eQ = 2'b11;
    endcase
    act = {phaseNeg, levelA, levelB, phaseOff, quadMon, awayFromHome};
    exp = {eNeg, 7'(eA), 7'(eB), eOff, eQ, expPos != 0};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s pos=%0d actual=%h expected=%h", tag, expPos, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; stepLevel = 1'b0; homeReq = 1'b0; enable = 1'b1;
    repeat (2) tick();
    rstN = 1'b1;
    tick();               // R1: first edge after release only samples
    expPos = 0;
  endtask

  task automatic toggle(bit d, string tag);
    dirCw = d;
    stepLevel = ~stepLevel;
    if ((stepLevel || !risingOnly) && enable)
      expPos = advance(expPos, d, stepOf(risingOnly, resSel));
    tick();
    checkAll(tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset state in a coarse and a fine mode
    risingOnly = 1'b1; resSel = 2'd0;
    doReset();
    checkAll("R1 reset state");
    risingOnly = 1'b0; resSel = 2'd3;
    doReset();
    checkAll("R1 reset state fine mode");

    // R2 R3 R4 R5 R9 R10 R11: sweep every mode word
    for (int m = 0; m < 8; m++) begin
      risingOnly = m[2];
      resSel = m[1:0];
      doReset();
      for (int i = 0; i < 64; i++) toggle(1'b1, "R2 R3 R4 R5 R9 R10 R11 sweep up");
      for (int i = 0; i < 20; i++) toggle(1'b0, "R2 R3 R4 R5 R9 sweep down");
    end

    // R6: fine to coarse while off grid, travelling up
    risingOnly = 1'b0; resSel = 2'd3;
    doReset();
    for (int i = 0; i < 3; i++) toggle(1'b1, "R6 fine steps");
    risingOnly = 1'b1; resSel = 2'd0;
    toggle(1'b1, "R6 falling edge in rising mode");
    toggle(1'b1, "R6 realign up to 16");
    checks++;
    if (expPos != 16) begin errors++; $display("FAIL R6 model pos=%0d expected=16", expPos); end
    // R6: travelling down after a change of grid
    risingOnly = 1'b0; resSel = 2'd3;
    for (int i = 0; i < 5; i++) toggle(1'b1, "R6 fine up to 21");
    risingOnly = 1'b0; resSel = 2'd1;
    toggle(1'b0, "R6 realign down to 20");
    toggle(1'b0, "R6 full step down to 16");

    // R7: home edge, held, released, and together with a step
    toggle(1'b1, "R7 move away");
    homeReq = 1'b1; expPos = 0; tick();
    checkAll("R7 home rising edge");
    toggle(1'b1, "R7 step while home held");
    toggle(1'b1, "R7 step while home held");
    homeReq = 1'b0; tick();
    checkAll("R7 home falling no effect");
    toggle(1'b1, "R7 step");
    homeReq = 1'b1; stepLevel = ~stepLevel; expPos = 0; tick();
    checkAll("R7 home wins over step");
    homeReq = 1'b0; tick();

    // R8: disable freezes position and drops edges
    for (int i = 0; i < 6; i++) toggle(1'b1, "R8 move away");
    enable = 1'b0; tick();
    checkAll("R8 disabled outputs off");
    toggle(1'b1, "R8 step ignored while disabled");
    toggle(1'b1, "R8 step ignored while disabled");
    toggle(1'b1, "R8 step ignored while disabled");
    homeReq = 1'b1; tick();
    checkAll("R8 home ignored while disabled");
    enable = 1'b1; tick();
    checkAll("R8 no phantom step on enable");
    homeReq = 1'b0; tick();
    toggle(1'b0, "R8 steps resume");

    // R11: a winding at zero current reports off
    risingOnly = 1'b1; resSel = 2'd3;
    doReset();
    for (int i = 0; i < 8; i++) toggle(1'b1, "R11 toward zero crossing");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule